// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address that a synchronous burst memory uses on each clock cycle. A start address is captured from the external bus when an active-low address-status strobe is seen on a rising clock edge. Two such strobes exist: one driven by a processor and one driven by a cache controller. After the load, the block steps through a four-beat burst, one beat for each cycle in which the active-low advance input is asserted. In a cycle with no load and no advance, the current address is held, which suspends the burst.

Only the two least-significant address bits are sequenced. A 2-bit beat counter is combined with the captured start bits in one of two ways. In linear order the block adds the counter to the start bits modulo 4. In interleaved order it XORs the counter with the start bits. The order select input chooses between the two and is examined in every cycle. The upper address bits stay exactly as they were loaded for the whole burst.

The processor strobe is qualified by a chip-enable input. The controller strobe is not. The address width is a parameter.

Top module: `burst_addr_seq`

## Requirements
- R1: With `sel_en` high, a low on `ads_proc_n` at a rising edge makes `addr_q` equal to `ext_addr` after that edge.
- R2: A low on `ads_ctrl_n` at a rising edge loads `ext_addr` into `addr_q`, whatever the level of `sel_en`.
- R3: With `sel_en` low and `ads_ctrl_n` high, a low on `ads_proc_n` loads nothing. The cycle is then treated as a strobe-free cycle, in which `adv_n` holds or advances the burst.
- R4: When both strobes are low in the same cycle, the processor strobe wins, and `ext_addr` from that cycle is the loaded address.
- R5: With `order_ilv` = 0 (linear), `addr_q[1:0]` = (start bits + beat count) mod 4.
- R6: With `order_ilv` = 1 (interleaved), `addr_q[1:0]` = start bits XOR beat count. For example, a start of 01 gives 01, 00, 11, 10.
- R7: In a cycle with no load, `adv_n` = 0 raises the beat count by one. `adv_n` = 1 holds the count, so `addr_q` stays unchanged while `order_ilv` is constant.
- R8: The beat count wraps from 3 to 0 and keeps cycling while advance stays low. Outside a load, `addr_q[ADDR_W-1:2]` never changes.
- R9: A rising edge with `rst` high clears the start address and the beat count, so `addr_q` is 0. `rst` takes precedence over any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | ADDR_W | External start address |
| ads_proc_n | input | 1 | Processor address-status strobe, active low |
| ads_ctrl_n | input | 1 | Controller address-status strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_ilv | input | 1 | 0 = linear order, 1 = interleaved order |
| sel_en | input | 1 | Chip-enable qualifier for the processor strobe, active high |
| addr_q | output | ADDR_W | Current burst address |

## Verification
The checker samples the inputs only at rising edges, outside reset, and never asks them to be stable between edges. The hold property therefore has to allow for a change of `order_ilv`: it excuses any cycle in which the order select differed from the cycle before. The bench drives all inputs at falling edges, so every input is settled well before the next rising edge. It switches the order select mid-burst only once, in a row whose expected value is computed with the new order.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  function automatic beat_t lin_low(input beat_t start, input beat_t cnt);
    return beat_t'(start + cnt);
  endfunction

  function automatic beat_t ilv_low(input beat_t start, input beat_t cnt);
    return start ^ cnt;
  endfunction

  function automatic beat_t burst_low(input beat_t start, input beat_t cnt, input logic ilv);
    return ilv ? ilv_low(start, cnt) : lin_low(start, cnt);
  endfunction
endpackage

// File: rtl/bsq_load_ctl.sv
module bsq_load_ctl (
  input  logic ads_proc_n,
  input  logic ads_ctrl_n,
  input  logic adv_n,
  input  logic sel_en,
  output logic load_fire,
  output logic step_fire
);
  logic proc_take;
  logic ctrl_take;

  // processor strobe is honoured only with chip enable; it has priority,
  // and both strobes load the same bus value
  assign proc_take = ~ads_proc_n & sel_en;
  assign ctrl_take = ~ads_ctrl_n & ~proc_take;
  assign load_fire = proc_take | ctrl_take;
  assign step_fire = ~load_fire & ~adv_n;
endmodule

// File: rtl/bsq_addr_reg.sv
module bsq_addr_reg #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_fire,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] start_q
);
  always_ff @(posedge clk) begin
    if (rst)            start_q <= '0;
    else if (load_fire) start_q <= ext_addr;
  end
endmodule

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
  import bsq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load_fire,
  input  logic  step_fire,
  output beat_t cnt_q
);
  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (load_fire) cnt_q <= '0;
    else if (step_fire) cnt_q <= beat_t'(cnt_q + 1'b1);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              ads_proc_n,
  input  logic              ads_ctrl_n,
  input  logic              adv_n,
  input  logic              order_ilv,
  input  logic              sel_en,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic              load_fire;
  logic              step_fire;
  logic [ADDR_W-1:0] start_q;
  beat_t             cnt_q;
  logic [UP_W-1:0]   upper_bits;
  beat_t             low_bits;

  bsq_load_ctl u_ctl (
    .ads_proc_n (ads_proc_n),
    .ads_ctrl_n (ads_ctrl_n),
    .adv_n      (adv_n),
    .sel_en     (sel_en),
    .load_fire  (load_fire),
    .step_fire  (step_fire)
  );

  bsq_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk       (clk),
    .rst       (rst),
    .load_fire (load_fire),
    .ext_addr  (ext_addr),
    .start_q   (start_q)
  );

  bsq_beat_ctr u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load_fire (load_fire),
    .step_fire (step_fire),
    .cnt_q     (cnt_q)
  );

  assign upper_bits = start_q[ADDR_W-1:BEAT_W];
  assign low_bits   = burst_low(start_q[BEAT_W-1:0], cnt_q, order_ilv);
  assign addr_q     = {upper_bits, low_bits};
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              ads_proc_n,
  input logic              ads_ctrl_n,
  input logic              adv_n,
  input logic              order_ilv,
  input logic              sel_en,
  input logic [ADDR_W-1:0] addr_q,
  input logic              load_fire,
  input logic              step_fire
);
  assert_load_proc_R1: assert property (@(posedge clk) disable iff (rst)
    (!ads_proc_n && sel_en) |=> addr_q == $past(ext_addr));

  assert_load_ctrl_R2: assert property (@(posedge clk) disable iff (rst)
    !ads_ctrl_n |=> addr_q == $past(ext_addr));

  assert_proc_masked_R3: assert property (@(posedge clk) disable iff (rst)
    (!ads_proc_n && !sel_en && ads_ctrl_n) |-> !load_fire);

  assert_linear_step_R5: assert property (@(posedge clk) disable iff (rst)
    (step_fire && !order_ilv) |=>
      (order_ilv || addr_q[1:0] == 2'($past(addr_q[1:0]) + 2'd1)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!load_fire && adv_n) |=>
      (order_ilv != $past(order_ilv) || addr_q == $past(addr_q)));

  assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (rst)
    !load_fire |=> addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2]));
endmodule

bind burst_addr_seq bsq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ext_addr   (ext_addr),
  .ads_proc_n (ads_proc_n),
  .ads_ctrl_n (ads_ctrl_n),
  .adv_n      (adv_n),
  .order_ilv  (order_ilv),
  .sel_en     (sel_en),
  .addr_q     (addr_q),
  .load_fire  (load_fire),
  .step_fire  (step_fire)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int AW = 17;
  localparam int NV = 16;

  typedef struct packed {
    logic          p_n;
    logic          c_n;
    logic          a_n;
    logic          ilv;
    logic          ce;
    logic [AW-1:0] ext;
    logic [AW-1:0] exp;
    logic [3:0]    req;
  } vec_t;

  // U = 12340, V = 0F0C0, W = 1FFFC (low bits 00)
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b1,1'b0,1'b1, 17'h12342, 17'h12342, 4'd1}, // R1 load
    '{1'b1,1'b1,1'b0,1'b0,1'b1, 17'h00000, 17'h12343, 4'd5}, // R5 linear
    '{1'b1,1'b1,1'b0,1'b0,1'b1, 17'h00000, 17'h12340, 4'd5}, // R5 wrap of low bits
    '{1'b1,1'b1,1'b0,1'b0,1'b1, 17'h00000, 17'h12341, 4'd5}, // R5
    '{1'b1,1'b1,1'b0,1'b0,1'b1, 17'h00000, 17'h12342, 4'd8}, // R8 counter wrap
    '{1'b1,1'b1,1'b1,1'b0,1'b1, 17'h1FFFF, 17'h12342, 4'd7}, // R7 hold
    '{1'b1,1'b0,1'b1,1'b1,1'b0, 17'h0F0C1, 17'h0F0C1, 4'd2}, // R2 ctrl load, ce low
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 17'h00000, 17'h0F0C0, 4'd6}, // R6 interleaved
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 17'h00000, 17'h0F0C3, 4'd6}, // R6
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 17'h00000, 17'h0F0C2, 4'd6}, // R6
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 17'h00000, 17'h0F0C1, 4'd8}, // R8 cycles on
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 17'h12340, 17'h0F0C1, 4'd3}, // R3 masked, hold
    '{1'b0,1'b1,1'b0,1'b1,1'b0, 17'h12340, 17'h0F0C0, 4'd3}, // R3 masked, advance
    '{1'b0,1'b0,1'b1,1'b0,1'b1, 17'h1FFFF, 17'h1FFFF, 4'd4}, // R4 both strobes
    '{1'b1,1'b1,1'b0,1'b0,1'b1, 17'h00000, 17'h1FFFC, 4'd8}, // R8 no carry upward
    '{1'b1,1'b1,1'b0,1'b1,1'b1, 17'h00000, 17'h1FFFD, 4'd6}  // R6 order switch: 11^10
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          ads_proc_n = 1'b1;
  logic          ads_ctrl_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          order_ilv = 1'b0;
  logic          sel_en = 1'b1;
  logic [AW-1:0] addr_q;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
    .clk        (clk),
    .rst        (rst),
    .ext_addr   (ext_addr),
    .ads_proc_n (ads_proc_n),
    .ads_ctrl_n (ads_ctrl_n),
    .adv_n      (adv_n),
    .order_ilv  (order_ilv),
    .sel_en     (sel_en),
    .addr_q     (addr_q)
  );

  task automatic check(input string tag, input logic [AW-1:0] exp);
    n_cmp++;
    if (addr_q !== exp) begin
      n_bad++;
      $display("FAIL %s: addr_q=%05h expected=%05h", tag, addr_q, exp);
    end
  endtask

  task automatic drive(input logic p, input logic c, input logic a, input logic i,
                       input logic e, input logic [AW-1:0] x);
    ads_proc_n = p; ads_ctrl_n = c; adv_n = a; order_ilv = i; sel_en = e; ext_addr = x;
    @(posedge clk); #1;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    check("R9 reset state", '0);
    rst = 1'b0;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(TBL[k].p_n, TBL[k].c_n, TBL[k].a_n, TBL[k].ilv, TBL[k].ce, TBL[k].ext);
      check($sformatf("R%0d vector %0d", TBL[k].req, k), TBL[k].exp);
    end
    // R9: reset wins over a simultaneous strobe
    @(negedge clk); rst = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 17'h0AAAA);
    check("R9 reset over strobe", '0);
    // R9: counter cleared, first advance gives 1
    @(negedge clk); rst = 1'b0;
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 17'h0);
    check("R9 counter cleared", 17'h00001);
    // R1/R7: load then hold with order held
    @(negedge clk); drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 17'h05553);
    check("R1 second load", 17'h05553);
    @(negedge clk); drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 17'h1FFFF);
    check("R7 hold after load", 17'h05553);
    // R6: start 11 interleaved first step 10
    @(negedge clk); drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 17'h0);
    check("R6 start 11 step", 17'h05552);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule